// File: doc/BRIEF.md
# Shared-Memory Command Ring Producer

This engine appends commands to a single-producer, single-consumer ring that lives in shared memory. A command of `ELEM_WORDS` data words arrives on a ready/valid input. The engine reaches memory only through a word-wide master port. It writes the command into the slot at its local tail, then stores the advanced tail index in memory, where the consumer can see it. The consumer owns the head index. The producer learns about free space only by reading that index back.

The ring region starts at `BASE_ADDR`. The first four words are control words: head, tail, capacity and one spare word. The slots follow them. The engine keeps a cached copy of head and reads head from memory only when that cached copy says the ring is full. While the ring stays full, the engine re-reads head on a fixed interval and holds the input stalled. It does not hammer the bus every cycle. A command is acknowledged only after its tail update has completed, so the consumer can never observe a half-written slot. A batch is sent as a series of single-slot commands.

Top module: `cmdring_producer`

## Requirements
- R1: With WB = DATA_W/8 bytes per word, head is at `BASE_ADDR`, tail is at `BASE_ADDR`+WB, and word w of slot s is at `BASE_ADDR` + (4 + s*ELEM_WORDS + w)*WB.
- R2: When (tail+1) mod CAPACITY equals the last head value read, the engine issues no slot or tail write and keeps `cmd_ready` low. It proceeds only after a re-read of head shows free space.
- R3: After a head read response that shows the ring full, the next head read request goes out exactly POLL_INTERVAL+1 cycles after the cycle in which that response was presented. Head is not read in between.
- R4: The slot words are written in order from word 0 to word ELEM_WORDS-1. Word w carries `cmd_data[w*DATA_W +: DATA_W]`. Every slot word is written before the tail write.
- R5: The tail write carries (tail+1) mod CAPACITY, zero-extended. It is issued only after the response to the last slot word. The engine never reads the tail word. Every read targets head.
- R6: `cmd_ready` is high for exactly one cycle: the cycle that follows the tail write response.
- R7: The engine reads head only when its cached head marks the ring full. After reset the cached head is 0.
- R8: From reset, with head held at 0 in memory, exactly CAPACITY-1 commands are accepted before the engine blocks.
- R9: The tail index wraps from CAPACITY-1 to 0. After the wrap, slot addresses start again at slot 0.
- R10: At most one memory transaction is outstanding. A request holds its valid, write flag, address and data stable until `mem_req_ready`. Each request receives exactly one `mem_rsp_valid` pulse.
- R11: During reset `cmd_ready` and `mem_req_valid` are low. The local tail and the cached head both start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; must stay high with stable data until accepted |
| cmd_ready | output | 1 | One-cycle acknowledge after the tail update has completed |
| cmd_data | input | ELEM_WORDS*DATA_W | Command words, word 0 in the low bits |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Response pulse for the outstanding request (read data or write done) |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
The bench builds the engine with CAPACITY=4, ELEM_WORDS=2, DATA_W=32, POLL_INTERVAL=5 and a base of 0x100. The small ring brings the full condition within reach after three commands. It also makes the tail wrap several times, so every slot address and every tail value is compared against arithmetic from the layout rule. With a short poll interval, the exact re-read spacing is measured many times during one blocked stretch, and the head-cache behaviour is checked by counting head reads per command. A request-ready pattern that stalls every third cycle exercises the hold-stable rule on the memory port.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

   typedef enum logic [3:0] {
      PS_IDLE,
      PS_HEAD_REQ,
      PS_HEAD_WAIT,
      PS_POLL,
      PS_SLOT_REQ,
      PS_SLOT_WAIT,
      PS_TAIL_REQ,
      PS_TAIL_WAIT,
      PS_ACK
   } prod_state_e;

   // Control words ahead of the first slot: head, tail, capacity, spare
   localparam int unsigned CTRL_WORDS = 4;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cmdring_addr_map.sv
module cmdring_addr_map
   import cmdring_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 32,
   parameter int unsigned        DATA_W     = 32,
   parameter int unsigned        ELEM_WORDS = 2,
   parameter int unsigned        CAPACITY   = 8,
   parameter logic [ADDR_W-1:0]  BASE_ADDR  = '0,
   localparam int unsigned       IDX_W      = $clog2(CAPACITY),
   localparam int unsigned       WIDX_W     = (ELEM_WORDS > 1) ? $clog2(ELEM_WORDS) : 1
) (
   input  logic [IDX_W-1:0]  slot_idx,
   input  logic [WIDX_W-1:0] word_idx,
   output logic [ADDR_W-1:0] head_addr,
   output logic [ADDR_W-1:0] tail_addr,
   output logic [ADDR_W-1:0] slot_word_addr
);

   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned BYTE_SHIFT = $clog2(WORD_BYTES);

   logic [ADDR_W-1:0] slot_base_words;
   logic [ADDR_W-1:0] word_index;

   generate
      if (is_pow2(ELEM_WORDS)) begin : g_shift
         localparam int unsigned ELEM_SHIFT = $clog2(ELEM_WORDS);
         assign slot_base_words = ADDR_W'(slot_idx) << ELEM_SHIFT;
      end else begin : g_mult
         assign slot_base_words = ADDR_W'(slot_idx) * ADDR_W'(ELEM_WORDS);
      end
   endgenerate

   assign word_index     = ADDR_W'(CTRL_WORDS) + slot_base_words + ADDR_W'(word_idx);
   assign slot_word_addr = BASE_ADDR + (word_index << BYTE_SHIFT);
   assign head_addr      = BASE_ADDR;
   assign tail_addr      = BASE_ADDR + ADDR_W'(WORD_BYTES);

endmodule

// File: rtl/cmdring_ring_ptr.sv
module cmdring_ring_ptr #(
   parameter int unsigned  CAPACITY = 8,
   localparam int unsigned IDX_W    = $clog2(CAPACITY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_load,
   input  logic [IDX_W-1:0] head_value,
   input  logic             tail_adv,
   output logic [IDX_W-1:0] tail_q,
   output logic [IDX_W-1:0] tail_next,
   output logic [IDX_W-1:0] head_cache,
   output logic             ring_full
);

   // IDX_W-bit arithmetic is the mask by CAPACITY-1
   assign tail_next = tail_q + 1'b1;
   assign ring_full = (tail_next == head_cache);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_q     <= '0;
         head_cache <= '0;
      end else begin
         if (tail_adv)  tail_q     <= tail_next;
         if (head_load) head_cache <= head_value;
      end
   end

   AST_FULL_BLOCKS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      ring_full |-> !tail_adv);  // R2

   AST_RESET_PTRS: assert property (@(posedge clk)
      !rst_n |=> (tail_q == '0) && (head_cache == '0));  // R11

endmodule

// File: rtl/cmdring_poll_timer.sv
module cmdring_poll_timer #(
   parameter int unsigned  POLL_INTERVAL = 16,
   localparam int unsigned CNT_W         = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);

   generate
      if (POLL_INTERVAL <= 1) begin : g_flag
         logic armed_q;
         always_ff @(posedge clk) begin
            if (!rst_n) armed_q <= 1'b0;
            else        armed_q <= start;
         end
         assign expired = armed_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic             run_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else if (start) begin
               cnt_q <= CNT_W'(POLL_INTERVAL - 1);
               run_q <= 1'b1;
            end else if (run_q) begin
               if (cnt_q == '0) run_q <= 1'b0;
               else             cnt_q <= cnt_q - 1'b1;
            end
         end
         assign expired = run_q && (cnt_q == '0);
      end
   endgenerate

   AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !expired);  // R3

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !expired || (POLL_INTERVAL <= 1));  // R3

endmodule

// File: rtl/cmdring_producer.sv
module cmdring_producer
   import cmdring_pkg::*;
#(
   parameter int unsigned        ADDR_W        = 32,
   parameter int unsigned        DATA_W        = 32,
   parameter int unsigned        ELEM_WORDS    = 2,
   parameter int unsigned        CAPACITY      = 8,
   parameter int unsigned        POLL_INTERVAL = 16,
   parameter logic [ADDR_W-1:0]  BASE_ADDR     = 'h1000,
   localparam int unsigned       CMD_W         = ELEM_WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [CMD_W-1:0]  cmd_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata
);

   localparam int unsigned IDX_W      = $clog2(CAPACITY);
   localparam int unsigned WIDX_W     = (ELEM_WORDS > 1) ? $clog2(ELEM_WORDS) : 1;
   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(ELEM_WORDS - 1);

   // Elaboration-time parameter checks
   initial begin
      if (!is_pow2(CAPACITY) || CAPACITY < 2)
         $fatal(1, "CAPACITY must be a power of two of at least 2");
      if ((DATA_W % 8) != 0 || !is_pow2(WORD_BYTES))
         $fatal(1, "DATA_W must be a power-of-two number of bytes");
      if (DATA_W <= IDX_W)
         $fatal(1, "DATA_W must exceed the ring index width");
      if (ELEM_WORDS < 1)
         $fatal(1, "ELEM_WORDS must be at least 1");
      if (POLL_INTERVAL < 1)
         $fatal(1, "POLL_INTERVAL must be at least 1");
      if ((BASE_ADDR % WORD_BYTES) != 0)
         $fatal(1, "BASE_ADDR must be word aligned");
   end

   prod_state_e state_q, state_d;
   logic [WIDX_W-1:0] word_idx_q;
   logic              word_step, word_clr;

   logic [IDX_W-1:0]  tail_q, tail_next, head_cache, rsp_head;
   logic              ring_full, head_load, tail_adv, head_is_full;
   logic              poll_start, poll_expired;
   logic [ADDR_W-1:0] head_addr, tail_addr, slot_addr;
   logic [DATA_W-IDX_W-1:0] rsp_upper;

   logic [DATA_W-1:0] cmd_words [ELEM_WORDS];

   generate
      for (genvar w = 0; w < ELEM_WORDS; w++) begin : g_words
         assign cmd_words[w] = cmd_data[w*DATA_W +: DATA_W];
      end
   endgenerate

   assign rsp_head     = mem_rsp_rdata[IDX_W-1:0];
   assign rsp_upper    = mem_rsp_rdata[DATA_W-1:IDX_W];
   assign head_is_full = (tail_next == rsp_head);

   cmdring_addr_map #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ELEM_WORDS (ELEM_WORDS),
      .CAPACITY   (CAPACITY),
      .BASE_ADDR  (BASE_ADDR)
   ) u_addr (
      .slot_idx       (tail_q),
      .word_idx       (word_idx_q),
      .head_addr      (head_addr),
      .tail_addr      (tail_addr),
      .slot_word_addr (slot_addr)
   );

   cmdring_ring_ptr #(
      .CAPACITY (CAPACITY)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_load  (head_load),
      .head_value (rsp_head),
      .tail_adv   (tail_adv),
      .tail_q     (tail_q),
      .tail_next  (tail_next),
      .head_cache (head_cache),
      .ring_full  (ring_full)
   );

   cmdring_poll_timer #(
      .POLL_INTERVAL (POLL_INTERVAL)
   ) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (poll_start),
      .expired (poll_expired)
   );

   always_comb begin
      state_d       = state_q;
      head_load     = 1'b0;
      tail_adv      = 1'b0;
      poll_start    = 1'b0;
      word_step     = 1'b0;
      word_clr      = 1'b0;
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = head_addr;
      mem_req_wdata = '0;
      cmd_ready     = 1'b0;
      unique case (state_q)
         PS_IDLE: begin
            if (cmd_valid) state_d = ring_full ? PS_HEAD_REQ : PS_SLOT_REQ;
         end
         PS_HEAD_REQ: begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) state_d = PS_HEAD_WAIT;
         end
         PS_HEAD_WAIT: begin
            if (mem_rsp_valid) begin
               head_load = 1'b1;
               if (head_is_full) begin
                  poll_start = 1'b1;
                  state_d    = PS_POLL;
               end else begin
                  state_d    = PS_SLOT_REQ;
               end
            end
         end
         PS_POLL: begin
            if (poll_expired) state_d = PS_HEAD_REQ;
         end
         PS_SLOT_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            mem_req_addr  = slot_addr;
            mem_req_wdata = cmd_words[word_idx_q];
            if (mem_req_ready) state_d = PS_SLOT_WAIT;
         end
         PS_SLOT_WAIT: begin
            if (mem_rsp_valid) begin
               if (word_idx_q == LAST_WORD) begin
                  word_clr = 1'b1;
                  state_d  = PS_TAIL_REQ;
               end else begin
                  word_step = 1'b1;
                  state_d   = PS_SLOT_REQ;
               end
            end
         end
         PS_TAIL_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            mem_req_addr  = tail_addr;
            mem_req_wdata = DATA_W'(tail_next);
            if (mem_req_ready) state_d = PS_TAIL_WAIT;
         end
         PS_TAIL_WAIT: begin
            if (mem_rsp_valid) begin
               tail_adv = 1'b1;
               state_d  = PS_ACK;
            end
         end
         PS_ACK: begin
            cmd_ready = 1'b1;
            state_d   = PS_IDLE;
         end
         default: state_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= PS_IDLE;
         word_idx_q <= '0;
      end else begin
         state_q <= state_d;
         if (word_clr)       word_idx_q <= '0;
         else if (word_step) word_idx_q <= word_idx_q + 1'b1;
      end
   end

   // Transaction tracker used only by the checks below
   logic outstanding_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                             outstanding_q <= 1'b0;
      else if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
      else if (mem_rsp_valid)                 outstanding_q <= 1'b0;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_wdata) && $stable(mem_req_write));  // R10

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding_q |-> !mem_req_valid);  // R10

   AST_READ_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> (mem_req_addr == BASE_ADDR));  // R5

   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |=> !cmd_ready);  // R6

   AST_ACK_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> $past(tail_adv));  // R6

   AST_HEAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_HEAD_WAIT && mem_rsp_valid) |-> (rsp_upper == '0));  // R2

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !cmd_ready && !mem_req_valid);  // R11

endmodule

// File: tb/cmdring_producer_tb.sv
module cmdring_producer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;
   localparam int DATA_W     = 32;
   localparam int ELEMS      = 2;
   localparam int CAP        = 4;
   localparam int POLL       = 5;
   localparam logic [ADDR_W-1:0] BASE = 16'h0100;
   localparam logic [ADDR_W-1:0] HEAD_A = BASE;
   localparam logic [ADDR_W-1:0] TAIL_A = BASE + 16'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [ELEMS*DATA_W-1:0] cmd_data = '0;
   logic mem_req_valid, mem_req_write;
   logic mem_req_ready = 1'b0;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [DATA_W-1:0] mem_req_wdata;
   logic mem_rsp_valid = 1'b0;
   logic [DATA_W-1:0] mem_rsp_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmdring_producer #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .ELEM_WORDS    (ELEMS),
      .CAPACITY      (CAP),
      .POLL_INTERVAL (POLL),
      .BASE_ADDR     (BASE)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_data      (cmd_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_rdata (mem_rsp_rdata)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Memory image: 4 control words + CAP*ELEMS slot words
   logic [DATA_W-1:0] mem_w [16];

   // Expected write stream
   logic [ADDR_W-1:0] exp_addr [64];
   logic [DATA_W-1:0] exp_data [64];
   bit                exp_tail_flag [64];
   int exp_wr = 0;
   int exp_rd = 0;
   int exp_tail = 0;

   int head_reads = 0;
   int poll_mark = 0;
   bit poll_armed = 0;
   int tail_rsp_cyc = -100;
   logic [DATA_W-1:0] last_tail_wr = '0;
   bit prev_req_valid = 0;

   logic              acc_write;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] acc_wdata;

   task automatic process_txn();
      int idx;
      idx = (int'(acc_addr) - int'(BASE)) / 4;
      if (!acc_write) begin
         chk(acc_addr == HEAD_A, "R5", 64'(acc_addr), 64'(HEAD_A));
         head_reads++;
         mem_rsp_rdata = mem_w[0];
         if (((exp_tail + 1) % CAP) == int'(mem_w[0])) begin
            poll_armed = 1;
            poll_mark  = cyc;
         end
      end else begin
         if (exp_rd < exp_wr) begin
            if (exp_tail_flag[exp_rd]) begin
               chk(acc_addr == exp_addr[exp_rd], "R1", 64'(acc_addr), 64'(exp_addr[exp_rd]));
               chk(acc_wdata == exp_data[exp_rd], "R5", 64'(acc_wdata), 64'(exp_data[exp_rd]));
            end else begin
               chk(acc_addr == exp_addr[exp_rd], "R1", 64'(acc_addr), 64'(exp_addr[exp_rd]));
               chk(acc_wdata == exp_data[exp_rd], "R4", 64'(acc_wdata), 64'(exp_data[exp_rd]));
            end
            exp_rd++;
         end else begin
            chk(1'b0, "R2", 64'(acc_addr), 64'(0));
         end
         if (acc_addr == TAIL_A) begin
            last_tail_wr = acc_wdata;
            tail_rsp_cyc = cyc;
         end
         if (idx >= 0 && idx < 16) mem_w[idx] = acc_wdata;
         mem_rsp_rdata = '0;
      end
   endtask

   // Memory model and monitor, acting on falling edges
   always @(negedge clk) begin
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
         mem_req_ready = 1'b0;
         process_txn();
         mem_rsp_valid = 1'b1;
      end else if (mem_req_valid) begin
         if (!prev_req_valid && !mem_req_write && poll_armed) begin
            chk((cyc - poll_mark) == POLL + 1, "R3", 64'(cyc - poll_mark), 64'(POLL + 1));
            poll_armed = 0;
         end
         if ((cyc % 3) != 0) begin
            mem_req_ready = 1'b1;
            acc_write = mem_req_write;
            acc_addr  = mem_req_addr;
            acc_wdata = mem_req_wdata;
         end
      end
      prev_req_valid = mem_req_valid;
   end

   task automatic expect_cmd(input logic [ELEMS*DATA_W-1:0] data);
      for (int w = 0; w < ELEMS; w++) begin
         exp_addr[exp_wr]      = BASE + ADDR_W'((4 + exp_tail * ELEMS + w) * 4);
         exp_data[exp_wr]      = data[w*DATA_W +: DATA_W];
         exp_tail_flag[exp_wr] = 1'b0;
         exp_wr++;
      end
      exp_addr[exp_wr]      = TAIL_A;
      exp_data[exp_wr]      = DATA_W'((exp_tail + 1) % CAP);
      exp_tail_flag[exp_wr] = 1'b1;
      exp_wr++;
      cmd_data  = data;
      cmd_valid = 1'b1;
   endtask

   task automatic wait_accept(input int limit, output bit accepted);
      accepted = 0;
      for (int n = 0; n < limit; n++) begin
         @(negedge clk);
         if (cmd_ready) begin
            accepted = 1;
            break;
         end
      end
      if (accepted) begin
         chk(cyc == tail_rsp_cyc + 1, "R6", 64'(cyc), 64'(tail_rsp_cyc + 1));
         @(negedge clk);
         cmd_valid = 1'b0;
         chk(!cmd_ready, "R6", 64'(cmd_ready), 64'(0));
         exp_tail = (exp_tail + 1) % CAP;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : stim
      bit ok;
      int reads_before;
      int wr_before;
      for (int i = 0; i < 16; i++) mem_w[i] = '0;
      mem_w[2] = DATA_W'(CAP);

      repeat (4) @(negedge clk);
      chk(!cmd_ready, "R11", 64'(cmd_ready), 64'(0));
      chk(!mem_req_valid, "R11", 64'(mem_req_valid), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R8 / R7: fill a ring whose consumer is stalled at head 0
      head_reads = 0;
      for (int i = 0; i < CAP - 1; i++) begin
         expect_cmd({32'hB0000000 | 32'(i), 32'hA0000000 | 32'(i * 3)});
         wait_accept(60, ok);
         chk(ok, "R8", 64'(ok), 64'(1));
      end
      chk(head_reads == 0, "R7", 64'(head_reads), 64'(0));

      // R2 / R3: the next command must block while head stays put
      head_reads = 0;
      wr_before  = exp_rd;
      expect_cmd({32'hDEAD0003, 32'hBEEF0003});
      wait_accept(60, ok);
      chk(!ok, "R2", 64'(ok), 64'(0));
      chk(exp_rd == wr_before, "R2", 64'(exp_rd), 64'(wr_before));
      chk(head_reads >= 2 && head_reads <= 60 / (POLL + 1) + 1, "R3",
          64'(head_reads), 64'(60 / (POLL + 1)));

      // Consumer frees one slot; the command must go through and wrap tail
      mem_w[0] = 32'd1;
      wait_accept(40, ok);
      chk(ok, "R2", 64'(ok), 64'(1));
      chk(last_tail_wr == 32'd0, "R9", 64'(last_tail_wr), 64'(0));
      chk(exp_tail == 0, "R9", 64'(exp_tail), 64'(0));

      // Consumer keeps up; tail wraps repeatedly
      for (int i = 0; i < 10; i++) begin
         mem_w[0] = DATA_W'(exp_tail);
         reads_before = head_reads;
         expect_cmd({32'h5A000000 ^ 32'(i * 7), 32'hC0DE0000 | 32'(i)});
         wait_accept(60, ok);
         chk(ok, "R9", 64'(ok), 64'(1));
         if (i == 0) chk(head_reads - reads_before == 1, "R7",
                         64'(head_reads - reads_before), 64'(1));
         if (i == 1) chk(head_reads - reads_before == 0, "R7",
                         64'(head_reads - reads_before), 64'(0));
      end
      repeat (4) @(negedge clk);
      chk(exp_rd == exp_wr, "R4", 64'(exp_rd), 64'(exp_wr));
      chk(mem_w[1] == DATA_W'(exp_tail), "R5", 64'(mem_w[1]), 64'(exp_tail));

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule